// File: doc/BRIEF.md
# ADC Conversion Sequencer and Serial Result Port

This block sits between the decimation filter of a delta-sigma converter and a three-wire serial host port. It starts conversions, decides when the analog side may be powered down, and shifts each finished result out to the host. The three pins are an active-low chip select, a serial clock and a data output with a separate output-enable. The chip select does three jobs. It enables the data driver. While it is held low, conversions run back to back. While it is held high, the converter idles in a low-power state once the running conversion has finished.

Each conversion gives exactly one output word, and no word is handed out twice as fresh data. Every fifth conversion (by default) is a hidden self-calibration cycle, and its result never reaches the host. The serial pins are sampled by the system clock through a short synchronizer, so the serial clock must run well below the system clock. A result is latched when the filter reports it done. It goes out as a 32-bit frame: a status bit, a dummy bit, the sign, the overrange flag, then the 28 data bits from the MSB down.

Top module: `adc_readout_ctrl`

## Requirements
- R1: `sdo_oe` is low whenever the sampled chip select is high and high whenever it is low; reset leaves it low.
- R2: While chip select is low and no conversion is running, `conv_start` pulses for one cycle. A new conversion starts right after each one completes, so conversions run back to back.
- R3: While chip select is high, no new conversion starts. A running conversion still completes, and `pwr_down` rises only once it has finished.
- R4: A frame is 32 bits in this transmit order: status (0 = unread fresh result, 1 = no fresh result), dummy bit 0, sign, overrange, then the 28 data bits MSB first.
- R5: The first frame bit appears on `sdo` when chip select falls. Each later bit appears after a falling edge of the serial clock, and the 32nd falling edge ends the frame.
- R6: Raising chip select in the middle of a frame aborts it. The result stays unread, and the next frame starts again at the first bit with the same word.
- R7: Finishing all 32 bits of a fresh frame marks the result as read. Until a new result is latched, the next frame carries status 1.
- R8: Every (CAL_EVERY+1)-th conversion is a calibration cycle: `conv_cal` is high from its start, and its completion latches nothing and leaves the frame status unchanged.
- R9: With chip select held low, a newly latched result is loaded into the frame when no bit of the current frame has been clocked out yet.
- R10: After reset, `pwr_down` is high, `sdo_oe` is low and no conversion starts while chip select stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Drive enable for the data pad (high = driven) |
| filt_done | input | 1 | One-cycle pulse: filter result ready |
| filt_sign | input | 1 | Sign of the filter result |
| filt_ovr | input | 1 | Overrange flag of the filter result |
| filt_data | input | DATA_W | Magnitude bits of the filter result |
| conv_start | output | 1 | One-cycle pulse starting a conversion |
| conv_cal | output | 1 | High while the current conversion is a calibration cycle |
| pwr_down | output | 1 | Request to power down the analog section |

## Verification
If the sequencer's busy or calibration count is wrong, the host sees it within one conversion period. A start appears while chip select is high, `pwr_down` rises before the filter reports done, or a calibration result turns up as a fresh frame with status 0. If the fresh-result bookkeeping in the shifter is wrong, the same word is delivered twice with status 0, or an aborted word is lost. This shows in the status bit of the very next frame. If the bit counter or shift register is off by one, every data bit after the slip is wrong. That shows within the same 32-bit frame, and the frame compare catches it.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    // status, dummy, sign and overrange precede the magnitude bits
    localparam int unsigned HDR_W = 4;

    typedef enum logic {
        STAT_FRESH = 1'b0,
        STAT_STALE = 1'b1
    } frame_stat_e;
endpackage

// File: rtl/adc_pin_sampler.sv
module adc_pin_sampler #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_pin,
    input  logic sclk_pin,
    output logic cs_lvl,
    output logic cs_fall,
    output logic sclk_fall
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] cs_sync;
        logic [SYNC_STAGES-1:0] ck_sync;
        logic                   cs_prev;
        logic                   ck_prev;
    } smp_t;

    smp_t s_d, s_q;
    logic [SYNC_STAGES-1:0] cs_next, ck_next;
    logic ck_lvl;

    if (SYNC_STAGES > 1) begin : g_chain
        always_comb begin
            cs_next = {s_q.cs_sync[SYNC_STAGES-2:0], cs_n_pin};
            ck_next = {s_q.ck_sync[SYNC_STAGES-2:0], sclk_pin};
        end
    end else begin : g_single
        always_comb begin
            cs_next = cs_n_pin;
            ck_next = sclk_pin;
        end
    end

    assign cs_lvl    = s_q.cs_sync[SYNC_STAGES-1];
    assign ck_lvl    = s_q.ck_sync[SYNC_STAGES-1];
    assign cs_fall   = s_q.cs_prev & ~cs_lvl;
    assign sclk_fall = s_q.ck_prev & ~ck_lvl;

    always_comb begin
        s_d         = s_q;
        s_d.cs_sync = cs_next;
        s_d.ck_sync = ck_next;
        s_d.cs_prev = cs_lvl;
        s_d.ck_prev = ck_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cs_sync <= '1;
            s_q.ck_sync <= '0;
            s_q.cs_prev <= 1'b1;
            s_q.ck_prev <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
    parameter int unsigned CAL_EVERY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_lvl,
    input  logic filt_done,
    output logic conv_start,
    output logic conv_cal,
    output logic pwr_down,
    output logic res_stb
);
    localparam int unsigned CNT_W = (CAL_EVERY < 1) ? 1 : $clog2(CAL_EVERY + 1);

    typedef struct packed {
        logic             busy;
        logic             cal;
        logic             start;
        logic             pd;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        res_stb   = s_q.busy && filt_done && !s_q.cal;
        if (s_q.busy && filt_done) begin
            s_d.busy = 1'b0;
        end else if (!s_q.busy && !cs_lvl) begin
            s_d.busy  = 1'b1;
            s_d.start = 1'b1;
            if (s_q.cnt == CNT_W'(CAL_EVERY)) begin
                s_d.cal = 1'b1;
                s_d.cnt = '0;
            end else begin
                s_d.cal = 1'b0;
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
        end
        s_d.pd = cs_lvl && !s_d.busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.busy  <= 1'b0;
            s_q.cal   <= 1'b0;
            s_q.start <= 1'b0;
            s_q.pd    <= 1'b1;
            s_q.cnt   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign conv_start = s_q.start;
    assign conv_cal   = s_q.cal;
    assign pwr_down   = s_q.pd;

    AST_PD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pd |-> !s_q.busy); // R3
    AST_CONV_RUNS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !filt_done) |=> s_q.busy); // R3
    AST_START_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.start |-> (s_q.busy && !s_q.pd)); // R2
    AST_START_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && !cs_lvl) |=> s_q.start); // R2
endmodule

// File: rtl/adc_frame_shifter.sv
module adc_frame_shifter
    import adc_rd_pkg::*;
#(
    parameter int unsigned DATA_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_lvl,
    input  logic              cs_fall,
    input  logic              sclk_fall,
    input  logic              res_stb,
    input  logic              res_sign,
    input  logic              res_ovr,
    input  logic [DATA_W-1:0] res_data,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int unsigned FRAME_W = DATA_W + HDR_W;
    localparam int unsigned BCNT_W  = $clog2(FRAME_W);
    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(FRAME_W - 1);

    typedef struct packed {
        logic               sign;
        logic               ovr;
        logic [DATA_W-1:0]  data;
        logic               fresh;
        logic               lf;
        logic               act;
        logic [BCNT_W-1:0]  bitcnt;
        logic [FRAME_W-1:0] sh;
        logic               sdo;
        logic               oe;
    } shf_t;

    shf_t s_d, s_q;
    frame_stat_e stat;
    logic [FRAME_W-1:0] frame;
    logic load;

    always_comb begin
        stat  = s_q.fresh ? STAT_FRESH : STAT_STALE;
        frame = {stat, 1'b0, s_q.sign, s_q.ovr, s_q.data};
        load  = cs_fall ||
                (!cs_lvl && s_q.fresh && !s_q.lf && (s_q.bitcnt == '0));

        s_d    = s_q;
        s_d.oe = !cs_lvl;
        if (cs_lvl) begin
            s_d.act    = 1'b0;
            s_d.bitcnt = '0;
            s_d.lf     = 1'b0;
            s_d.sdo    = 1'b0;
        end else if (load) begin
            s_d.sh     = frame;
            s_d.act    = 1'b1;
            s_d.bitcnt = '0;
            s_d.lf     = s_q.fresh;
            s_d.sdo    = frame[FRAME_W-1];
        end else if (sclk_fall && s_q.act) begin
            if (s_q.bitcnt == LAST_BIT) begin
                s_d.act    = 1'b0;
                s_d.bitcnt = '0;
                s_d.sdo    = 1'b0;
                s_d.lf     = 1'b0;
                if (s_q.lf) s_d.fresh = 1'b0;
            end else begin
                s_d.sh     = s_q.sh << 1;
                s_d.sdo    = s_q.sh[FRAME_W-2];
                s_d.bitcnt = s_q.bitcnt + BCNT_W'(1);
            end
        end
        if (res_stb) begin
            s_d.sign  = res_sign;
            s_d.ovr   = res_ovr;
            s_d.data  = res_data;
            s_d.fresh = 1'b1;
            s_d.lf    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sdo    = s_q.sdo;
    assign sdo_oe = s_q.oe;

    AST_IDLE_WHEN_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.oe |-> !s_q.act); // R1
    AST_LOAD_AT_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (s_q.act && s_q.bitcnt == '0)); // R5
    AST_BIT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_fall && s_q.act && !cs_lvl && s_q.bitcnt != '0 && s_q.bitcnt != LAST_BIT)
        |=> s_q.bitcnt == $past(s_q.bitcnt) + BCNT_W'(1)); // R5
    AST_ABORT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        cs_lvl |=> (!s_q.act && s_q.bitcnt == '0)); // R6
    AST_STB_MAKES_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        res_stb |=> s_q.fresh); // R7
endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl #(
    parameter int unsigned DATA_W      = 28,
    parameter int unsigned CAL_EVERY   = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              filt_done,
    input  logic              filt_sign,
    input  logic              filt_ovr,
    input  logic [DATA_W-1:0] filt_data,
    output logic              conv_start,
    output logic              conv_cal,
    output logic              pwr_down
);
    logic cs_lvl, cs_fall, sclk_fall, res_stb;

    adc_pin_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_pin  (cs_n),
        .sclk_pin  (sclk),
        .cs_lvl    (cs_lvl),
        .cs_fall   (cs_fall),
        .sclk_fall (sclk_fall)
    );

    adc_conv_seq #(.CAL_EVERY(CAL_EVERY)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_lvl     (cs_lvl),
        .filt_done  (filt_done),
        .conv_start (conv_start),
        .conv_cal   (conv_cal),
        .pwr_down   (pwr_down),
        .res_stb    (res_stb)
    );

    adc_frame_shifter #(.DATA_W(DATA_W)) u_shf (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_lvl    (cs_lvl),
        .cs_fall   (cs_fall),
        .sclk_fall (sclk_fall),
        .res_stb   (res_stb),
        .res_sign  (filt_sign),
        .res_ovr   (filt_ovr),
        .res_data  (filt_data),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );
endmodule

// File: tb/sim_adc_readout_ctrl.sv
module sim_adc_readout_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WAIT_CYC   = 6;
    localparam int CONV_CYC   = 2000;
    localparam int CAL_N      = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdo, sdo_oe;
    logic        filt_done = 1'b0;
    logic        filt_sign = 1'b0;
    logic        filt_ovr = 1'b0;
    logic [27:0] filt_data = '0;
    logic        conv_start, conv_cal, pwr_down;

    int n_chk = 0;
    int n_fail = 0;
    int n_start = 0;
    int n_norm = 0;
    int n_norm_done = 0;
    bit fin = 1'b0;
    logic [31:0] exp_q[$];

    adc_readout_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .sdo(sdo), .sdo_oe(sdo_oe),
        .filt_done(filt_done), .filt_sign(filt_sign), .filt_ovr(filt_ovr),
        .filt_data(filt_data),
        .conv_start(conv_start), .conv_cal(conv_cal), .pwr_down(pwr_down)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (WAIT_CYC) @(negedge clk);
    endtask

    // sample the bit already on sdo, then n falling edges of the serial clock
    task automatic read_bits(input int n, output logic [31:0] w);
        w = '0;
        w[31] = sdo;
        for (int i = 1; i <= n; i++) begin
            sclk = 1'b1; settle();
            sclk = 1'b0; settle();
            if (i < 32) w[31-i] = sdo;
        end
    endtask

    function automatic logic [31:0] pop_newest();
        logic [31:0] v;
        v = exp_q[$];
        exp_q.delete();
        return v;
    endfunction

    // filter model and expected-item driver
    initial begin
        bit exp_cal;
        logic [31:0] mix;
        forever begin
            @(negedge clk);
            if (rst_n && conv_start) begin
                exp_cal = ((n_start % (CAL_N + 1)) == CAL_N);
                chk("R8 conv_cal at start", {31'd0, conv_cal}, {31'd0, exp_cal});
                n_start++;
                repeat (CONV_CYC) @(negedge clk);
                if (exp_cal) begin
                    filt_sign = 1'b1; filt_ovr = 1'b1; filt_data = '1;
                end else begin
                    n_norm++;
                    mix = 32'h09A5_C3E1 ^ (n_norm * 32'h0135_7913);
                    filt_sign = mix[0] ^ n_norm[0];
                    filt_ovr  = n_norm[1];
                    filt_data = mix[27:0];
                    exp_q.push_back({1'b0, 1'b0, filt_sign, filt_ovr, filt_data});
                end
                filt_done = 1'b1;
                @(negedge clk);
                filt_done = 1'b0;
                if (!exp_cal) n_norm_done++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] w, e, prev;
        int starts_before;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk("R10 pwr_down after reset", {31'd0, pwr_down}, 32'd1);
        chk("R10 sdo_oe after reset", {31'd0, sdo_oe}, 32'd0);
        chk("R10 no start with cs high", n_start, 0);

        // continuous conversion
        cs_n = 1'b0; settle();
        chk("R2 first start on cs low", n_start, 1);
        chk("R1 sdo_oe with cs low", {31'd0, sdo_oe}, 32'd1);
        chk("R2 pwr_down released", {31'd0, pwr_down}, 32'd0);
        chk("R4 status bit stale before any result", {31'd0, sdo}, 32'd1);

        for (int k = 1; k <= 5; k++) begin
            while (n_norm_done < k) @(negedge clk);
            settle();
            read_bits(32, w);
            chk("R9 R4 auto-loaded frame", w, pop_newest());
            if (k == 4) begin
                while (n_start < 6) @(negedge clk);
                settle();
                cs_n = 1'b1; settle();
                chk("R1 sdo_oe with cs high", {31'd0, sdo_oe}, 32'd0);
                cs_n = 1'b0; settle();
                chk("R8 calibration result hidden", {31'd0, sdo}, 32'd1);
            end
        end
        chk("R2 back-to-back starts", n_start, 7);

        // abort and no-repeat
        while (n_norm_done < 6) @(negedge clk);
        settle();
        e = exp_q[$];
        read_bits(9, w);
        chk("R5 partial frame bits", {22'd0, w[31:22]}, {22'd0, e[31:22]});
        cs_n = 1'b1; settle();
        cs_n = 1'b0; settle();
        read_bits(32, w);
        prev = pop_newest();
        chk("R6 frame restarts after abort", w, prev);
        cs_n = 1'b1; settle();
        cs_n = 1'b0; settle();
        chk("R7 status after completed read", {31'd0, sdo}, 32'd1);
        read_bits(32, w);
        chk("R7 stale frame content", w, {1'b1, prev[30:0]});

        // power down after the running conversion
        cs_n = 1'b1; settle();
        starts_before = n_start;
        chk("R3 no power down mid-conversion", {31'd0, pwr_down}, 32'd0);
        while (n_norm_done < 7) @(negedge clk);
        settle();
        chk("R3 power down after completion", {31'd0, pwr_down}, 32'd1);
        repeat (300) @(negedge clk);
        chk("R3 no start while cs high", n_start, starts_before);
        chk("R1 sdo_oe off in power down", {31'd0, sdo_oe}, 32'd0);
        cs_n = 1'b0; settle();
        chk("R2 wake starts conversion", n_start, starts_before + 1);
        read_bits(32, w);
        chk("R4 result finished in power down", w, pop_newest());
        cs_n = 1'b1; settle();

        fin = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule